// File: doc/BRIEF.md
# Token Bucket Packet Policer

The block meters a stream of packet requests against a committed token bucket and, when enabled, a second peak bucket. Each request carries a packet length. The block answers one cycle later with a color (green, yellow or red) and a pass/drop verdict that comes from a per-color action input. Incoming packet color is not considered, so the block always meters in blind mode.

Refill amounts, bucket ceilings and the per-packet adjustment are all given as an exponent and mantissa pair. Such a pair stands for (1 + M/256)·2^E bytes. Token counts are held with 8 fractional bits, so a resolution of 1/256 token is exact.

Refill happens once every 2^div base ticks. A base tick lasts 2 µs and is `TICK_CYCLES` clock cycles long. A byte/packet mode bit together with the adjust pair sets the cost of each packet. A packet is charged either by its length or at a fixed cost per packet.

Top module: `pkt_policer`

## Requirements
- R1: Under reset each bucket loads its full ceiling and rsp_valid is 0. When reset is released, the committed bucket therefore admits packets up to its burst size with no wait.
- R2: A response (rsp_valid=1) appears exactly one cycle after each cycle with req_valid=1, and at no other time.
- R3: With the peak bucket disabled, a packet whose cost is no greater than the committed level is green (rsp_color=0) and its cost is subtracted. Otherwise it is red (rsp_color=2) and the level is not charged.
- R4: A refill event occurs when the base counter reaches TICK_CYCLES-1 and the divider count has reached 2^div-1. It then adds (256+M)·2^E /256 bytes to each bucket, so the period is TICK_CYCLES·2^div cycles.
- R5: A bucket's level never exceeds (256+M)·2^E /256 bytes of its burst pair. Tokens that would go above this ceiling are lost.
- R6: The cost is computed as (mode ? 0 : length) + (A_M/256 − 1)·2^A_E, with A_E clamped to 24. If this is below 1/256, the cost is raised to 1/256.
- R7: Packet mode (mode=1, A_M=384, A_E=1) charges exactly one token per packet, whatever the length.
- R8: The pair E=24, M=0 gives zero. If the committed burst is zero, every packet is red. If the peak burst is zero, the peak bucket is switched off and no packet is yellow.
- R9: With the peak bucket on, a packet is red if the peak level is below its cost, and then neither bucket is charged. It is yellow if only the committed level is too low, and then only the peak bucket is charged. Otherwise it is green and both buckets are charged.
- R10: A rate or burst exponent above 22 (other than the zero pair) acts as 22.
- R11: rsp_drop equals the drop input of the reported color, as that input stood in the request cycle.
- R12: When a request and a refill fall in the same cycle, the request is judged against the level before the refill. Its cost and the refill are then applied together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cir_exp | input | 5 | Committed refill exponent |
| cir_man | input | 8 | Committed refill mantissa |
| cbs_exp | input | 5 | Committed burst exponent |
| cbs_man | input | 8 | Committed burst mantissa |
| pir_exp | input | 5 | Peak refill exponent |
| pir_man | input | 8 | Peak refill mantissa |
| pbs_exp | input | 5 | Peak burst exponent |
| pbs_man | input | 8 | Peak burst mantissa |
| tick_div | input | 4 | Refill every 2^tick_div base ticks |
| pkt_mode | input | 1 | 1: length not charged |
| adj_exp | input | 5 | Cost adjust exponent |
| adj_man | input | 9 | Cost adjust mantissa |
| drop_green | input | 1 | Drop action for green |
| drop_yellow | input | 1 | Drop action for yellow |
| drop_red | input | 1 | Drop action for red |
| req_valid | input | 1 | Packet request strobe |
| req_len | input | 16 | Packet length in bytes |
| rsp_valid | output | 1 | Verdict strobe |
| rsp_color | output | 2 | 0 green, 1 yellow, 2 red |
| rsp_drop | output | 1 | 1 when the packet is dropped |

## Verification
The assertions check on every cycle:
- the one-cycle response timing;
- that a level rises only on a refill event;
- that the color follows from the level and cost seen in the request cycle;
- that no yellow appears while the peak bucket is off;
- that the drop bit matches the action of its color.

Only the bench scenarios can show the absolute amounts, because each needs a known configuration and a count over many packets:
- the refill amount and period;
- the ceiling value;
- the exponent clamp at 22;
- the 1/256 cost floor;
- the one-token packet mode.

// File: rtl/policer_pkg.sv
package policer_pkg;
  localparam int TOK_W   = 40;  // token width, 8 fractional bits
  localparam int LEN_W   = 16;
  localparam int EXP_MAX = 22;
  localparam int ADJ_MAX = 24;

  typedef enum logic [1:0] {
    CLR_GREEN  = 2'd0,
    CLR_YELLOW = 2'd1,
    CLR_RED    = 2'd2
  } pcolor_t;

  // (1 + m/256) * 2^e in 1/256 units; pair 24/0 means zero
  function automatic logic [TOK_W-1:0] fp_tokens(input logic [4:0] e, input logic [7:0] m);
    logic [4:0] ee;
    if (e == 5'd24 && m == 8'd0) return '0;
    ee = (e > 5'(EXP_MAX)) ? 5'(EXP_MAX) : e;
    return TOK_W'({1'b0, m} + 9'd256) << ee;
  endfunction

  function automatic logic [TOK_W-1:0] pkt_cost(input logic mode, input logic [LEN_W-1:0] len,
                                                 input logic [4:0] ae, input logic [8:0] am);
    logic signed [47:0] base, adj, sum;
    logic [4:0] ee;
    ee   = (ae > 5'(ADJ_MAX)) ? 5'(ADJ_MAX) : ae;
    base = mode ? 48'sd0 : $signed({24'd0, len, 8'd0});
    adj  = $signed({39'd0, am}) - 48'sd256;
    adj  = adj <<< ee;
    sum  = base + adj;
    if (sum < 48'sd1) return TOK_W'(1);
    return TOK_W'(sum);
  endfunction
endpackage

// File: rtl/policer_tick.sv
module policer_tick #(
  parameter int TICK_CYCLES = 500,
  parameter int DIV_W       = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div,
  output logic             refill_o
);
  localparam int CW  = $clog2(TICK_CYCLES + 1);
  localparam int DCW = 1 << DIV_W;

  logic [CW-1:0]  base_q;
  logic [DCW-1:0] div_q;
  logic [DCW-1:0] mask;
  logic           base_wrap;

  assign base_wrap = (base_q == CW'(TICK_CYCLES - 1));
  assign mask      = (DCW'(1) << div) - DCW'(1);
  assign refill_o  = base_wrap && (div_q >= mask);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q <= '0;
      div_q  <= '0;
    end else begin
      base_q <= base_wrap ? '0 : base_q + CW'(1);
      if (base_wrap) div_q <= (div_q >= mask) ? '0 : div_q + DCW'(1);
    end
  end
endmodule

// File: rtl/policer_bucket.sv
module policer_bucket #(
  parameter int TW = 40
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [TW-1:0] cap,
  input  logic [TW-1:0] rate,
  input  logic [TW-1:0] cost,
  input  logic          refill,
  input  logic          debit,
  output logic [TW-1:0] level
);
  logic [TW-1:0] sum;

  assign sum = level - (debit ? cost : '0) + (refill ? rate : '0);

  always_ff @(posedge clk) begin
    if (!rst_n) level <= cap;
    else        level <= (sum > cap) ? cap : sum;
  end
endmodule

// File: rtl/policer_classify.sv
module policer_classify
  import policer_pkg::*;
#(
  parameter int TW = 40
) (
  input  logic [TW-1:0] c_level,
  input  logic [TW-1:0] p_level,
  input  logic [TW-1:0] cost,
  input  logic          peak_on,
  output pcolor_t       color,
  output logic          c_debit,
  output logic          p_debit
);
  always_comb begin
    c_debit = 1'b0;
    p_debit = 1'b0;
    color   = CLR_RED;
    if (peak_on) begin
      if (p_level >= cost) begin
        p_debit = 1'b1;
        if (c_level >= cost) begin
          c_debit = 1'b1;
          color   = CLR_GREEN;
        end else begin
          color   = CLR_YELLOW;
        end
      end
    end else if (c_level >= cost) begin
      c_debit = 1'b1;
      color   = CLR_GREEN;
    end
  end
endmodule

// File: rtl/pkt_policer.sv
module pkt_policer
  import policer_pkg::*;
#(
  parameter int TICK_CYCLES = 500,
  parameter int DIV_W       = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [4:0]       cir_exp,
  input  logic [7:0]       cir_man,
  input  logic [4:0]       cbs_exp,
  input  logic [7:0]       cbs_man,
  input  logic [4:0]       pir_exp,
  input  logic [7:0]       pir_man,
  input  logic [4:0]       pbs_exp,
  input  logic [7:0]       pbs_man,
  input  logic [DIV_W-1:0] tick_div,
  input  logic             pkt_mode,
  input  logic [4:0]       adj_exp,
  input  logic [8:0]       adj_man,
  input  logic             drop_green,
  input  logic             drop_yellow,
  input  logic             drop_red,
  input  logic             req_valid,
  input  logic [LEN_W-1:0] req_len,
  output logic             rsp_valid,
  output logic [1:0]       rsp_color,
  output logic             rsp_drop
);
  localparam int TW = TOK_W;

  logic [TW-1:0] c_level, p_level, cost;
  logic          refill, peak_on;
  logic          c_debit, p_debit;
  pcolor_t       color;
  logic          drop_sel;

  assign cost    = pkt_cost(pkt_mode, req_len, adj_exp, adj_man);
  assign peak_on = !(pbs_exp == 5'd24 && pbs_man == 8'd0);

  policer_tick #(.TICK_CYCLES(TICK_CYCLES), .DIV_W(DIV_W)) u_tick (
    .clk(clk), .rst_n(rst_n), .div(tick_div), .refill_o(refill));

  policer_classify #(.TW(TW)) u_cls (
    .c_level(c_level), .p_level(p_level), .cost(cost), .peak_on(peak_on),
    .color(color), .c_debit(c_debit), .p_debit(p_debit));

  policer_bucket #(.TW(TW)) u_cbkt (
    .clk(clk), .rst_n(rst_n),
    .cap(fp_tokens(cbs_exp, cbs_man)), .rate(fp_tokens(cir_exp, cir_man)),
    .cost(cost), .refill(refill), .debit(req_valid && c_debit), .level(c_level));

  policer_bucket #(.TW(TW)) u_pbkt (
    .clk(clk), .rst_n(rst_n),
    .cap(fp_tokens(pbs_exp, pbs_man)), .rate(fp_tokens(pir_exp, pir_man)),
    .cost(cost), .refill(refill), .debit(req_valid && p_debit), .level(p_level));

  always_comb begin
    case (color)
      CLR_GREEN:  drop_sel = drop_green;
      CLR_YELLOW: drop_sel = drop_yellow;
      default:    drop_sel = drop_red;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_color <= 2'd0;
      rsp_drop  <= 1'b0;
    end else begin
      rsp_valid <= req_valid;
      if (req_valid) begin
        rsp_color <= color;
        rsp_drop  <= drop_sel;
      end
    end
  end
endmodule

// File: rtl/pkt_policer_chk.sv
module pkt_policer_chk #(
  parameter int TW = 40
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          rsp_valid,
  input logic [1:0]    rsp_color,
  input logic          rsp_drop,
  input logic          drop_green,
  input logic          drop_yellow,
  input logic          drop_red,
  input logic [TW-1:0] c_level,
  input logic [TW-1:0] p_level,
  input logic [TW-1:0] cost,
  input logic          refill,
  input logic          peak_on
);
  // R2
  rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  // R2
  no_spurious_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);
  // R4
  rise_only_on_refill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !refill |=> c_level <= $past(c_level));
  // R3
  green_when_covered_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !peak_on && c_level >= cost |=> rsp_color == 2'd0);
  // R3
  red_when_short_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !peak_on && c_level < cost |=> rsp_color == 2'd2);
  // R9
  peak_short_red_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && peak_on && p_level < cost |=> rsp_color == 2'd2);
  // R8
  no_yellow_peak_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !$past(peak_on) |-> rsp_color != 2'd1);
  // R6
  cost_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cost >= TW'(1));
  // R11
  drop_red_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_color == 2'd2 |-> rsp_drop == $past(drop_red));
  // R11
  drop_green_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_color == 2'd0 |-> rsp_drop == $past(drop_green));
  // R11
  drop_yellow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_color == 2'd1 |-> rsp_drop == $past(drop_yellow));
endmodule

bind pkt_policer pkt_policer_chk #(.TW(policer_pkg::TOK_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .rsp_valid(rsp_valid),
  .rsp_color(rsp_color), .rsp_drop(rsp_drop), .drop_green(drop_green),
  .drop_yellow(drop_yellow), .drop_red(drop_red), .c_level(c_level),
  .p_level(p_level), .cost(cost), .refill(refill), .peak_on(peak_on));

// File: tb/pkt_policer_test.sv
module pkt_policer_test;
  localparam int T = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [4:0] cir_exp, cbs_exp, pir_exp, pbs_exp, adj_exp;
  logic [7:0] cir_man, cbs_man, pir_man, pbs_man;
  logic [3:0] tick_div;
  logic pkt_mode, drop_green, drop_yellow, drop_red, req_valid;
  logic [8:0] adj_man;
  logic [15:0] req_len;
  logic rsp_valid, rsp_drop;
  logic [1:0] rsp_color;

  always #2 clk = ~clk;  // 250 MHz

  pkt_policer #(.TICK_CYCLES(T), .DIV_W(4)) uut (
    .clk(clk), .rst_n(rst_n), .cir_exp(cir_exp), .cir_man(cir_man),
    .cbs_exp(cbs_exp), .cbs_man(cbs_man), .pir_exp(pir_exp), .pir_man(pir_man),
    .pbs_exp(pbs_exp), .pbs_man(pbs_man), .tick_div(tick_div), .pkt_mode(pkt_mode),
    .adj_exp(adj_exp), .adj_man(adj_man), .drop_green(drop_green),
    .drop_yellow(drop_yellow), .drop_red(drop_red), .req_valid(req_valid),
    .req_len(req_len), .rsp_valid(rsp_valid), .rsp_color(rsp_color), .rsp_drop(rsp_drop));

  int checks = 0, errors = 0, cycles = 0;
  int g_cnt = 0, y_cnt = 0, r_cnt = 0;
  string tag = "R1";

  // behavioural reference
  longint m_c, m_p, m_bc, m_dc;
  bit e_valid; int e_color; bit e_drop;

  function automatic longint amount(int e, int m);
    if (e == 24 && m == 0) return 0;
    if (e > 22) e = 22;
    return longint'(256 + m) * (longint'(1) << e);
  endfunction

  function automatic longint charge(bit mode, int len, int ae, int am);
    longint c;
    if (ae > 24) ae = 24;
    c = mode ? 0 : longint'(len) * 256;
    c = c + longint'(am - 256) * (longint'(1) << ae);
    return (c < 1) ? 1 : c;
  endfunction

  always @(posedge clk) begin
    longint cap_c, cap_p, cost, dc_c, dc_p;
    bit rf, pon;
    cap_c = amount(cbs_exp, cbs_man);
    cap_p = amount(pbs_exp, pbs_man);
    if (!rst_n) begin
      m_c = cap_c; m_p = cap_p; m_bc = 0; m_dc = 0; e_valid = 0;
    end else begin
      rf   = (m_bc == T - 1) && (m_dc >= (longint'(1) << tick_div) - 1);
      pon  = !(pbs_exp == 24 && pbs_man == 0);
      cost = charge(pkt_mode, req_len, adj_exp, adj_man);
      dc_c = 0; dc_p = 0;
      e_valid = req_valid;
      if (req_valid) begin
        if (pon && m_p < cost)      e_color = 2;
        else if (m_c < cost)        begin e_color = pon ? 1 : 2; if (pon) dc_p = cost; end
        else                        begin e_color = 0; dc_c = cost; if (pon) dc_p = cost; end
        e_drop = (e_color == 0) ? drop_green : (e_color == 1) ? drop_yellow : drop_red;
      end
      m_c = m_c - dc_c + (rf ? amount(cir_exp, cir_man) : 0);
      m_p = m_p - dc_p + (rf ? amount(pir_exp, pir_man) : 0);
      if (m_c > cap_c) m_c = cap_c;
      if (m_p > cap_p) m_p = cap_p;
      if (m_bc == T - 1) begin
        m_dc = (m_dc >= (longint'(1) << tick_div) - 1) ? 0 : m_dc + 1;
        m_bc = 0;
      end else m_bc = m_bc + 1;
    end
  end

  // compare on every cycle, away from the active edge
  always @(negedge clk) begin
    cycles++;
    checks++;
    if (rsp_valid !== e_valid) begin
      errors++;
      $display("FAIL %s: rsp_valid=%0d expected %0d", (rst_n ? "R2" : "R1"), rsp_valid, e_valid);
    end else if (e_valid) begin
      checks++;
      if (rsp_color !== 2'(e_color) || rsp_drop !== e_drop) begin
        errors++;
        $display("FAIL %s: color/drop=%0d/%0d expected %0d/%0d", tag, rsp_color, rsp_drop, e_color, e_drop);
      end
      if (rsp_color == 2'd0) g_cnt++;
      else if (rsp_color == 2'd1) y_cnt++;
      else r_cnt++;
    end
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog: cycles=%0d expected below 150000", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic check_eq(string t, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", t, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0; req_valid = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    g_cnt = 0; y_cnt = 0; r_cnt = 0;
  endtask

  task automatic send(int len, int n, int gap);
    for (int i = 0; i < n; i++) begin
      req_valid = 1; req_len = 16'(len);
      @(negedge clk);
      req_valid = 0;
      repeat (gap) @(negedge clk);
    end
    req_valid = 0;
    @(negedge clk);
  endtask

  task automatic base_cfg();
    cir_exp = 0; cir_man = 0; cbs_exp = 10; cbs_man = 0;
    pir_exp = 24; pir_man = 0; pbs_exp = 24; pbs_man = 0;
    tick_div = 4; pkt_mode = 0; adj_exp = 0; adj_man = 256;
    drop_green = 0; drop_yellow = 0; drop_red = 1;
  endtask

  initial begin
    base_cfg(); req_valid = 0; req_len = 0;
    @(negedge clk); @(negedge clk);
    check_eq("R1 rsp_valid in reset", int'(rsp_valid), 0);

    // R1 R3: 1024-byte burst, 100-byte packets, negligible refill
    tag = "R3"; do_reset();
    send(100, 12, 0);
    check_eq("R1 greens from full bucket", g_cnt, 10);
    check_eq("R3 reds once drained", r_cnt, 2);

    // R4 R12: 64 bytes every 8 cycles, drain then trickle
    tag = "R4"; cir_exp = 6; tick_div = 1; do_reset();
    send(100, 12, 0);
    send(64, 40, 3);
    send(60, 30, 0);
    tag = "R12"; send(64, 60, 0);

    // R5: long idle then burst; ceiling limits the greens
    tag = "R5"; cir_exp = 8; tick_div = 0; do_reset();
    send(1024, 1, 0);
    repeat (200) @(negedge clk);
    g_cnt = 0; r_cnt = 0;
    send(512, 3, 0);
    check_eq("R5 greens capped at burst", g_cnt, 2);

    // R6: floor of 1/256 token, bucket of one token
    tag = "R6"; base_cfg(); cbs_exp = 0; tick_div = 15; adj_exp = 8; adj_man = 0;
    do_reset();
    send(0, 300, 0);
    check_eq("R6 greens at 1/256 cost", g_cnt, 256);

    // R7: packet mode, four-token bucket
    tag = "R7"; base_cfg(); cbs_exp = 2; tick_div = 15;
    pkt_mode = 1; adj_exp = 1; adj_man = 384; do_reset();
    send(1500, 6, 0);
    check_eq("R7 one token per packet", g_cnt, 4);

    // R8: committed burst zero -> all red
    tag = "R8"; base_cfg(); cbs_exp = 24; cbs_man = 0; do_reset();
    send(1, 5, 1);
    check_eq("R8 zero bucket all red", r_cnt, 5);

    // R9: peak on, committed 200, peak 512 bytes
    tag = "R9"; base_cfg(); cbs_exp = 7; cbs_man = 144; pbs_exp = 9; pbs_man = 0;
    tick_div = 15; do_reset();
    send(100, 7, 0);
    check_eq("R9 greens", g_cnt, 2);
    check_eq("R9 yellows", y_cnt, 3);
    check_eq("R9 reds", r_cnt, 2);

    // R10: burst exponent 31 acts as 22
    tag = "R10"; base_cfg(); cbs_exp = 31; tick_div = 15; do_reset();
    send(65535, 66, 0);
    check_eq("R10 burst clamp greens", g_cnt, 64);
    cir_exp = 30; tick_div = 0; cbs_exp = 23; do_reset();
    send(65535, 100, 0);

    // R11: swapped actions
    tag = "R11"; base_cfg(); drop_green = 1; drop_red = 0; drop_yellow = 1;
    cbs_exp = 8; pbs_exp = 9; tick_div = 15; do_reset();
    send(100, 8, 0);
    check_eq("R11 yellow seen", int'(y_cnt > 0), 1);

    repeat (4) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule